// File: doc/BRIEF.md
# Exponent-Aware Input Scaler

This block sits at the front of a wideband receive channel. Each clock it takes one converter sample and turns it into a wider fixed-point word before the sample goes on to decimation. A sample has two parts: a 14-bit two's-complement mantissa and a 3-bit unsigned exponent. The exponent comes from a gain-ranging or floating-point converter; for a plain fixed-point converter it is tied to zero. The block derives a right-shift amount of 0 to 7 from the exponent. It places the mantissa above seven zero fraction bits and shifts it arithmetically. No precision is lost and the sign is never lost.

The shift can run in two directions. In the normal direction, the exponent plus a programmable offset, taken modulo 8, gives the right shift. In the inverted direction, seven minus the exponent plus the offset, taken modulo 8, gives it. With inversion a larger exponent means less attenuation. The offset comes from one of two 5-bit fields held side by side in a single configuration word. The loud field is used while an external attenuator is switched in. The quiet field is used otherwise.

The attenuator flag passes through a history register with a programmable tap of 0 to 7 cycles, so that a gain change lines up with the samples it affected. The selected tap is named `SEL_LOUD` or `SEL_QUIET`. Narrower converters are connected MSB-justified, with their unused low mantissa bits held at zero.

Top module: `fps_expo_scaler`

## Requirements
- R1: While `rst_n` is low, `samp_o` is zero and the attenuator history is cleared. History from before reset is read as a quiet flag.
- R2: The mantissa and exponent present at rising edge N decide the value of `samp_o` after rising edge N+1 (one register stage of latency).
- R3: `samp_o` is the 21-bit value {mantissa, 7'b0}, arithmetically shifted right by the shift amount (0 to 7). Vacated upper bits are filled with the mantissa sign.
- R4: With `invert_i` = 0, the shift is (exponent + field[2:0]) mod 8. With exponent 0 and field 0, `samp_o` equals the mantissa times 128.
- R5: With `invert_i` = 1, the shift is (7 − exponent + field[2:0]) mod 8. With field 6, exponent 5 gives shift 0 and exponent 0 gives shift 5.
- R6: The field is `scale_pair_i[4:0]` (loud) when the effective attenuator flag is 1, and `scale_pair_i[9:5]` (quiet) when it is 0. `invert_i` and `scale_pair_i` are taken as they stand at the edge that loads `samp_o`.
- R7: Bits 4:3 of either field have no effect on `samp_o`.
- R8: The effective flag for the sample captured at edge N is the `atten_i` value captured at edge N − `flag_delay_i` (delay 0 to 7). `flag_delay_i` is taken at the edge that loads `samp_o`.
- R9: The sign bit of `samp_o` always equals the sign bit of the mantissa it came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mant_i | input | 14 | Two's-complement mantissa |
| expo_i | input | 3 | Unsigned exponent |
| atten_i | input | 1 | External attenuator active |
| invert_i | input | 1 | Invert exponent direction |
| scale_pair_i | input | 10 | Quiet field [9:5], loud field [4:0] |
| flag_delay_i | input | 3 | Attenuator flag alignment delay in cycles |
| samp_o | output | 21 | Scaled sample |

## Verification
The hardest case to reach from the ports is a mismatch between the flag tap and the sample it is meant to align with. Such a mismatch only shows when the attenuator flag changes often and the two fields give different shifts. The stimulus therefore sweeps every delay from 0 to 7. Within each delay it toggles the flag pseudo-randomly on every cycle, with loud and quiet fields set to distinct values and random exponents. An off-by-one in the tap then changes the output within a few cycles. Separate phases drive full-scale positive and negative mantissas, and set the upper field bits to prove they have no effect.

// File: rtl/fps_pkg.sv
package fps_pkg;
    localparam int MANT_W     = 14;
    localparam int EXP_W      = 3;
    localparam int FIELD_W    = 5;
    localparam int DLY_W      = 3;
    localparam int SHIFT_SPAN = (1 << EXP_W) - 1;
    localparam int OUT_W      = MANT_W + SHIFT_SPAN;
    localparam int PAIR_W     = 2 * FIELD_W;

    typedef logic signed [MANT_W-1:0] mant_t;
    typedef logic [EXP_W-1:0]         expo_t;
    typedef logic signed [OUT_W-1:0]  wide_t;

    typedef enum logic {
        SEL_QUIET = 1'b0,
        SEL_LOUD  = 1'b1
    } scale_sel_e;
endpackage

// File: rtl/fps_capture.sv
module fps_capture
    import fps_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mant_t mant_i,
    input  expo_t expo_i,
    output mant_t mant_q,
    output expo_t expo_q
);
    // Input register: one sample per rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mant_q <= '0;
            expo_q <= '0;
        end else begin
            mant_q <= mant_i;
            expo_q <= expo_i;
        end
    end
endmodule

// File: rtl/fps_flag_delay.sv
module fps_flag_delay
    import fps_pkg::*;
#(
    parameter int SEL_W = DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_i,
    input  logic [SEL_W-1:0] tap_i,
    output scale_sel_e       sel_o
);
    localparam int DEPTH = 1 << SEL_W;

    logic [DEPTH-1:0] hist;

    // hist[k] holds the flag captured k edges before the newest one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[DEPTH-2:0], flag_i};
    end

    always_comb sel_o = scale_sel_e'(hist[tap_i]);

    logic warm1_q, warm2_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm1_q <= 1'b0;
            warm2_q <= 1'b0;
        end else begin
            warm1_q <= 1'b1;
            warm2_q <= warm1_q;
        end
    end

    // R8: tap 0 presents the flag taken at the previous edge
    assert_tap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n || !warm1_q)
        (tap_i == '0) |-> (sel_o == scale_sel_e'($past(flag_i))));

    // R8: tap 1 presents the flag taken two edges back
    assert_tap_one_R8: assert property (@(posedge clk) disable iff (!rst_n || !warm2_q)
        (tap_i == SEL_W'(1)) |-> (sel_o == scale_sel_e'($past(flag_i, 2))));
endmodule

// File: rtl/fps_shift_unit.sv
module fps_shift_unit
    import fps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mant_t             mant_i,
    input  expo_t             expo_i,
    input  logic              invert_i,
    input  logic [PAIR_W-1:0] scale_pair_i,
    input  scale_sel_e        sel_i,
    output wide_t             samp_o
);
    expo_t field_lo;
    expo_t expo_eff;
    expo_t shift;
    logic  unused_hi;

    always_comb begin
        unique case (sel_i)
            SEL_LOUD:  field_lo = scale_pair_i[EXP_W-1:0];
            SEL_QUIET: field_lo = scale_pair_i[FIELD_W+EXP_W-1:FIELD_W];
            default:   field_lo = '0;
        endcase
        // 7 - e equals the bitwise complement for an unsigned EXP_W-bit value.
        expo_eff = invert_i ? ~expo_i : expo_i;
        shift    = expo_eff + field_lo; // wraps modulo 2**EXP_W
    end

    // Upper field bits never reach the shift amount.
    assign unused_hi = ^{scale_pair_i[FIELD_W-1:EXP_W],
                         scale_pair_i[PAIR_W-1:FIELD_W+EXP_W]};

    // Logarithmic arithmetic barrel shifter.
    wide_t stg [EXP_W+1];
    assign stg[0] = wide_t'({mant_i, {SHIFT_SPAN{1'b0}}});

    for (genvar k = 0; k < EXP_W; k++) begin : g_stage
        assign stg[k+1] = shift[k] ? (stg[k] >>> (1 << k)) : stg[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_o <= '0;
        else        samp_o <= stg[EXP_W];
    end

    logic warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    // R3: a zero mantissa stays zero for every shift
    assert_zero_stays_R3: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        ($past(mant_i) == '0) |-> (samp_o == '0));
endmodule

// File: rtl/fps_expo_scaler.sv
module fps_expo_scaler
    import fps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MANT_W-1:0] mant_i,
    input  logic [EXP_W-1:0]  expo_i,
    input  logic              atten_i,
    input  logic              invert_i,
    input  logic [PAIR_W-1:0] scale_pair_i,
    input  logic [DLY_W-1:0]  flag_delay_i,
    output logic [OUT_W-1:0]  samp_o
);
    mant_t      mant_q;
    expo_t      expo_q;
    scale_sel_e sel;
    wide_t      samp_w;

    fps_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .mant_i (mant_t'(mant_i)),
        .expo_i (expo_i),
        .mant_q (mant_q),
        .expo_q (expo_q)
    );

    fps_flag_delay #(.SEL_W(DLY_W)) u_flag_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (atten_i),
        .tap_i  (flag_delay_i),
        .sel_o  (sel)
    );

    fps_shift_unit u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .mant_i       (mant_q),
        .expo_i       (expo_q),
        .invert_i     (invert_i),
        .scale_pair_i (scale_pair_i),
        .sel_i        (sel),
        .samp_o       (samp_w)
    );

    assign samp_o = samp_w;

    logic warm1_q, warm2_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm1_q <= 1'b0;
            warm2_q <= 1'b0;
        end else begin
            warm1_q <= 1'b1;
            warm2_q <= warm1_q;
        end
    end

    // R9: sign of the output follows the mantissa two edges back
    assert_sign_kept_R9: assert property (@(posedge clk) disable iff (!rst_n || !warm2_q)
        samp_o[OUT_W-1] == $past(mant_i[MANT_W-1], 2));

    // R4: fixed-point pass-through when exponent, offsets and invert are zero
    assert_passthrough_R4: assert property (@(posedge clk) disable iff (!rst_n || !warm2_q)
        ($past(!invert_i && scale_pair_i[EXP_W-1:0] == '0 &&
               scale_pair_i[FIELD_W+EXP_W-1:FIELD_W] == '0) && $past(expo_i, 2) == '0)
        |-> (samp_o == {$past(mant_i, 2), {SHIFT_SPAN{1'b0}}}));

    // R5: inverted exponent 5 with offset 6 gives no shift
    assert_invert_top_R5: assert property (@(posedge clk) disable iff (!rst_n || !warm2_q)
        ($past(invert_i && scale_pair_i[EXP_W-1:0] == EXP_W'(6) &&
               scale_pair_i[FIELD_W+EXP_W-1:FIELD_W] == EXP_W'(6)) && $past(expo_i, 2) == EXP_W'(5))
        |-> (samp_o == {$past(mant_i, 2), {SHIFT_SPAN{1'b0}}}));
endmodule

// File: tb/fps_expo_scaler_tb.sv
`timescale 1ns/1ps
module fps_expo_scaler_tb;
    import fps_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MANT_W-1:0] mant = '0;
    logic [EXP_W-1:0]  expo = '0;
    logic              atten = 1'b0;
    logic              invert = 1'b0;
    logic [PAIR_W-1:0] scale = '0;
    logic [DLY_W-1:0]  dly = '0;
    logic [OUT_W-1:0]  samp;

    always #2.5 clk = ~clk;

    fps_expo_scaler u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mant_i       (mant),
        .expo_i       (expo),
        .atten_i      (atten),
        .invert_i     (invert),
        .scale_pair_i (scale),
        .flag_delay_i (dly),
        .samp_o       (samp)
    );

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    bit done   = 1'b0;

    logic [MANT_W-1:0] h_m   [0:4095];
    logic [EXP_W-1:0]  h_e   [0:4095];
    logic              h_a   [0:4095];
    logic              h_inv [0:4095];
    logic [PAIR_W-1:0] h_sc  [0:4095];
    logic [DLY_W-1:0]  h_d   [0:4095];

    function automatic logic [OUT_W-1:0] model(input logic [MANT_W-1:0] m, input logic [EXP_W-1:0] e,
                                               input logic inv, input logic [FIELD_W-1:0] fld);
        int sh;
        logic signed [OUT_W-1:0] w;
        sh = inv ? (7 - int'(e) + int'(fld)) : (int'(e) + int'(fld));
        sh = sh % 8;
        w  = $signed({m, 7'b0});
        return w >>> sh;
    endfunction

    task automatic compare(input string tag, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, n, act, expv);
        end
    endtask

    // Apply one sample, pass one rising edge, then compare against the model.
    task automatic cycle(input string tag, input logic [MANT_W-1:0] m, input logic [EXP_W-1:0] e, input logic a);
        logic [OUT_W-1:0] expv;
        logic flag;
        logic [FIELD_W-1:0] fld;
        int src;
        mant = m; expo = e; atten = a;
        @(negedge clk);
        h_m[n] = m; h_e[n] = e; h_a[n] = a;
        h_inv[n] = invert; h_sc[n] = scale; h_d[n] = dly;
        if (n == 0) begin
            expv = '0;
        end else begin
            src  = n - 1 - int'(h_d[n]);
            flag = (src >= 0) ? h_a[src] : 1'b0;
            fld  = flag ? h_sc[n][4:0] : h_sc[n][9:5];
            expv = model(h_m[n-1], h_e[n-1], h_inv[n], fld);
        end
        compare(tag, samp, expv);
        n++;
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(11));
        // R1: output held at zero in reset, flag driven high to test history clearing
        mant = 14'h1ABC; expo = 3'd3; atten = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare("R1", samp, '0);
        end
        rst_n = 1'b1;

        // R2/R4: fixed-point pass-through including full-scale extremes
        invert = 1'b0; scale = '0; dly = '0;
        cycle("R2", 14'h2000, 3'd0, 1'b0);
        cycle("R4", 14'h1FFF, 3'd0, 1'b0);
        cycle("R4", 14'h3FFF, 3'd0, 1'b0);
        cycle("R4", 14'h0001, 3'd0, 1'b0);
        for (int i = 0; i < 16; i++) cycle("R4", 14'($urandom), 3'd0, 1'b0);

        // R3/R9: exponent drives right shift with sign extension
        cycle("R3", 14'h2000, 3'd7, 1'b0);
        cycle("R3", 14'h1FFF, 3'd7, 1'b0);
        cycle("R3", 14'h0000, 3'd5, 1'b0);
        for (int i = 0; i < 40; i++) cycle("R3/R9", 14'($urandom), 3'($urandom), 1'b0);

        // R5: inverted exponent with offset 6 in both fields
        invert = 1'b1; scale = {5'd6, 5'd6};
        cycle("R5", 14'h1234, 3'd5, 1'b0);
        cycle("R5", 14'h1234, 3'd0, 1'b0);
        cycle("R5", 14'h2345, 3'd7, 1'b1);
        for (int i = 0; i < 40; i++) cycle("R5", 14'($urandom), 3'($urandom), 1'($urandom));

        // R6: loud and quiet fields differ, flag random, tap 0
        invert = 1'b0; scale = {5'd1, 5'd3};
        for (int i = 0; i < 40; i++) cycle("R6", 14'($urandom), 3'($urandom), 1'($urandom));
        invert = 1'b1;
        for (int i = 0; i < 20; i++) cycle("R6", 14'($urandom), 3'($urandom), 1'($urandom));

        // R7: upper field bits set, only low three bits may matter
        invert = 1'b0; scale = {5'b10110, 5'b11001};
        for (int i = 0; i < 40; i++) cycle("R7", 14'($urandom), 3'($urandom), 1'($urandom));
        scale = {5'b01110, 5'b00001};
        for (int i = 0; i < 20; i++) cycle("R7", 14'($urandom), 3'($urandom), 1'($urandom));

        // R8: sweep every flag delay with a frequently toggling flag
        scale = {5'd0, 5'd4};
        for (int d = 0; d < 8; d++) begin
            dly = 3'(d);
            invert = d[0];
            for (int i = 0; i < 40; i++) cycle("R8", 14'($urandom), 3'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule